// File: doc/BRIEF.md
# Charge Fail-Safe Timer and Fault Status

This block guards a battery charge cycle. It runs a minute-based watchdog whose period is chosen by a 3-bit select, and it keeps a set of sticky fault flags fed by comparator outputs: cell over-voltage, end-of-discharge under-voltage, over-temperature and under-temperature. When the watchdog runs out, or any of those faults has been seen, the fail-safe output rises so a charge controller can stop charging. Two battery presence and polarity indications are passed through live. Everything is reported in one 8-bit status byte.

A host loads a configuration word by pulsing `cfg_load` while the serial select `cs` is low. The word carries a new timeout select and a clear command. The clear command stays in force, holding the elapsed-minute count at zero and emptying every fault flag, until `cs` returns high. At that point the command withdraws itself. There is no data stream at the boundary. All pins are plain level control and status signals with no handshake.

Top module: `failsafe_monitor`

## Requirements
- R1: After reset the status byte reads 0 when all fault inputs are low, fail_safe is 0, and the timeout select is code 0, so the fifth minute tick with no configuration load sets the timeout flag.
- R2: Select codes 0 to 6 give a period of 5·2^code minutes. The timeout flag (status bit 6) is 0 after period−1 ticks and reads 1 two clock cycles after the tick that completes the period.
- R3: Select code 7 never times out, however many ticks arrive.
- R4: While the clear command is held, the elapsed count stays at 0 and all sticky flags (status bits 2 to 7) read 0. After a clear, a full new period of ticks is needed before a timeout.
- R5: The clear command drops on the first clock edge after `cs` is seen rising. Fault pulses while it is held are not recorded, and pulses after its release are recorded.
- R6: Status bit 0 follows `bat_present` and bit 1 follows `bat_reversed` in the same cycle. Neither is held.
- R7: A one-cycle pulse on `cell_overvolt`, `cell_undervolt`, `temp_high` or `temp_low` sets status bit 2, 3, 4 or 5 in turn, and the bit stays set after the input falls.
- R8: Status bit 7 and the `fail_safe` output equal the OR of status bits 2 to 6.
- R9: A select change loaded without a clear takes effect at once against the elapsed count. A shorter period already passed times out within two cycles, and a longer one needs only the remaining ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Loads cfg_tsel and cfg_clear (cs low) |
| cfg_tsel | input | 3 | Timeout select code |
| cfg_clear | input | 1 | Clear command bit |
| cs | input | 1 | Serial select; rising edge withdraws clear |
| minute_tick | input | 1 | One-cycle pulse per elapsed minute |
| bat_present | input | 1 | Battery-present comparator |
| bat_reversed | input | 1 | Reversed or shorted comparator |
| cell_overvolt | input | 1 | Cell over-voltage comparator |
| cell_undervolt | input | 1 | End-of-discharge comparator |
| temp_high | input | 1 | Over-temperature comparator |
| temp_low | input | 1 | Under-temperature comparator |
| status | output | 8 | {fail-safe, timeout, cold, hot, undervolt, overvolt, reversed, present} |
| fail_safe | output | 1 | Stop-charging flag |

## Verification
The bench looks for an off-by-one at every period length. A design that compares against the wrong limit shows the timeout flag one tick early or late. It also checks that code 7 stays silent past the largest count, which a design would miss if it let the counter wrap or treated 7 as a shift like the others. A select change made mid-run is tested in both directions: a design that restarted the count, or latched the old limit, would time out late or never. The bench also checks that the clear command is held until `cs` rises, that fault pulses are dropped while it is held, and that a clear restarts the count, which a design that only reset the flags would fail.

// File: rtl/fsmon_pkg.sv
package fsmon_pkg;
  localparam int STAT_W    = 8;
  localparam int N_STICKY  = 5;   // overvolt, undervolt, hot, cold, timeout
  localparam int IDX_TOUT  = 4;   // position of timeout within the sticky vector
  localparam int SEL_W_DEF = 3;
endpackage

// File: rtl/fsmon_timer.sv
module fsmon_timer #(
  parameter int BASE_MIN = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             clear,
  input  logic             tick,
  output logic             expired
);
  localparam int MAX_SHIFT = (1 << SEL_W) - 2;
  localparam int CNT_W     = $clog2((BASE_MIN << MAX_SHIFT) + 1);
  localparam logic [SEL_W-1:0] SEL_NEVER = '1;

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] limit;

  always_comb limit = CNT_W'(BASE_MIN) << sel;

  assign expired = (sel != SEL_NEVER) && (elapsed >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   elapsed <= '0;
    else if (clear)                               elapsed <= '0;
    else if (tick && !expired && (elapsed != '1)) elapsed <= elapsed + 1'b1;
  end

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (elapsed == '0));
  assert_hold_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> $stable(elapsed));
endmodule

// File: rtl/fsmon_latches.sv
module fsmon_latches #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] set_in,
  output logic [N-1:0] held
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held[i] <= 1'b0;
      else if (clear)     held[i] <= 1'b0;
      else if (set_in[i]) held[i] <= 1'b1;
    end

    assert_flag_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && !clear) |=> held[i]);
    assert_flag_captures_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_in[i] && !clear) |=> held[i]);
  end

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (held == '0));
endmodule

// File: rtl/failsafe_monitor.sv
module failsafe_monitor
  import fsmon_pkg::*;
#(
  parameter int BASE_MIN = 5,
  parameter int SEL_W    = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [SEL_W-1:0] cfg_tsel,
  input  logic             cfg_clear,
  input  logic             cs,
  input  logic             minute_tick,
  input  logic             bat_present,
  input  logic             bat_reversed,
  input  logic             cell_overvolt,
  input  logic             cell_undervolt,
  input  logic             temp_high,
  input  logic             temp_low,
  output logic [STAT_W-1:0] status,
  output logic             fail_safe
);
  localparam logic [SEL_W-1:0] SEL_NEVER = '1;

  logic [SEL_W-1:0]    tsel_q;
  logic                clr_q;
  logic                cs_q;
  logic                cs_rise;
  logic                expired;
  logic [N_STICKY-1:0] set_vec;
  logic [N_STICKY-1:0] held;

  assign cs_rise = cs && !cs_q;

  // Configuration word and self-withdrawing clear command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= '0;
      clr_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      cs_q <= cs;
      if (cfg_load) tsel_q <= cfg_tsel;
      if (cs_rise)       clr_q <= 1'b0;
      else if (cfg_load) clr_q <= cfg_clear;
    end
  end

  fsmon_timer #(.BASE_MIN(BASE_MIN), .SEL_W(SEL_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (tsel_q),
    .clear   (clr_q),
    .tick    (minute_tick),
    .expired (expired)
  );

  assign set_vec = {expired, temp_low, temp_high, cell_undervolt, cell_overvolt};

  fsmon_latches #(.N(N_STICKY)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr_q),
    .set_in (set_vec),
    .held   (held)
  );

  assign fail_safe = |held;
  assign status    = {fail_safe, held, bat_reversed, bat_present};

  assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |=> !clr_q);
  assert_never_expires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel_q == SEL_NEVER && !held[IDX_TOUT]) |=> !held[IDX_TOUT]);
  assert_failsafe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held == '0) |-> !status[STAT_W-1]);
endmodule

// File: tb/sim_failsafe_monitor.sv
module sim_failsafe_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_tsel = 3'd0;
  logic       cfg_clear = 1'b0;
  logic       cs = 1'b1;
  logic       minute_tick = 1'b0;
  logic [5:0] flt = 6'd0;   // {cold, hot, undervolt, overvolt, reversed, present}
  logic [7:0] status;
  logic       fail_safe;
  int vectors = 0;
  int errs = 0;

  always #5ns clk = ~clk;

  failsafe_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_tsel(cfg_tsel),
    .cfg_clear(cfg_clear), .cs(cs), .minute_tick(minute_tick),
    .bat_present(flt[0]), .bat_reversed(flt[1]), .cell_overvolt(flt[2]),
    .cell_undervolt(flt[3]), .temp_high(flt[4]), .temp_low(flt[5]),
    .status(status), .fail_safe(fail_safe)
  );

  // {fault inputs, expected status after the sticky inputs drop}
  localparam logic [13:0] VECS [9] = '{
    {6'b000000, 8'h00}, {6'b000001, 8'h01}, {6'b000010, 8'h02},
    {6'b000100, 8'h84}, {6'b001000, 8'h88}, {6'b010000, 8'h90},
    {6'b100000, 8'hA0}, {6'b111111, 8'hBF}, {6'b000011, 8'h03}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic clr, input logic release_cs);
    @(negedge clk);
    cs = 1'b0; cfg_load = 1'b1; cfg_tsel = sel; cfg_clear = clr;
    @(negedge clk);
    cfg_load = 1'b0; cfg_clear = 1'b0;
    if (release_cs) begin
      cs = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); minute_tick = 1'b1;
      @(negedge clk); minute_tick = 1'b0;
    end
  endtask

  initial begin
    #2ms;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset fail_safe", {7'd0, fail_safe}, 8'h00);
    ticks(4);
    check("R1 default 4 ticks", status, 8'h00);
    ticks(1);
    @(negedge clk);
    check("R1 default period 5", status, 8'hC0);

    // Table walk: R6 live, R7 sticky, R8 OR
    for (int v = 0; v < 9; v++) begin
      load(3'd7, 1'b1, 1'b1);
      @(negedge clk); flt = VECS[v][13:8];
      @(negedge clk); flt = VECS[v][13:8] & 6'b000011;
      @(negedge clk);
      check("R7 sticky table", status, VECS[v][7:0]);
      check("R8 fail_safe pin", {7'd0, fail_safe}, {7'd0, VECS[v][7]});
      flt = 6'd0;
      #1ns;
      check("R6 live bits drop", {6'd0, status[1:0]}, 8'h00);
    end

    // R2: every finite period
    for (int c = 0; c < 7; c++) begin
      load(3'(c), 1'b1, 1'b1);
      check("R4 cleared before period", status, 8'h00);
      ticks((5 << c) - 1);
      @(negedge clk);
      check("R2 one tick short", status, 8'h00);
      ticks(1);
      @(negedge clk);
      check("R2 period reached", status, 8'hC0);
    end

    // R3: infinite code
    load(3'd7, 1'b1, 1'b1);
    ticks(600);
    @(negedge clk);
    check("R3 never expires", status, 8'h00);

    // R9: shrink below elapsed count
    load(3'd3, 1'b1, 1'b1);
    ticks(20);
    check("R9 before shrink", status, 8'h00);
    load(3'd1, 1'b0, 1'b1);
    @(negedge clk);
    check("R9 shrink expires", status, 8'hC0);
    // R9: grow above elapsed count
    load(3'd1, 1'b1, 1'b1);
    ticks(8);
    load(3'd2, 1'b0, 1'b1);
    ticks(11);
    @(negedge clk);
    check("R9 grow remaining-1", status, 8'h00);
    ticks(1);
    @(negedge clk);
    check("R9 grow remaining", status, 8'hC0);

    // R4: clear restarts the count
    load(3'd0, 1'b1, 1'b1);
    ticks(3);
    load(3'd0, 1'b1, 1'b1);
    ticks(4);
    @(negedge clk);
    check("R4 count restarted", status, 8'h00);
    ticks(1);
    @(negedge clk);
    check("R4 full period after clear", status, 8'hC0);

    // R5: clear held until cs rises
    load(3'd7, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    flt = 6'b000100;
    @(negedge clk); flt = 6'd0;
    @(negedge clk);
    check("R5 pulse ignored while held", status, 8'h00);
    cs = 1'b1;
    repeat (2) @(negedge clk);
    flt = 6'b010000;
    @(negedge clk); flt = 6'd0;
    @(negedge clk);
    check("R5 recorded after cs rise", status, 8'h90);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule